// File: doc/BRIEF.md
# Boundary-Scan Test Access Port

This block is the serial test port of a device: a sixteen-state controller stepped by a mode line on the rising edge of the test clock, a three-bit instruction register, and three data registers that can be placed between the serial input and the serial output. The data registers are a single-cell bypass register, a 32-bit identification register and a boundary register whose length is a parameter (54 cells by default).

The latched instruction selects the data register. It also drives two controls for the functional logic. One is a strobe that tells the functional logic to capture its pin values into the boundary register. The other is a float request that tells the functional logic to place its data and match outputs in high impedance. The serial output changes on the falling edge of the test clock. An output-enable line qualifies it, so the pad can present high impedance outside the two shift states.

Top module: `scan_tap`

## Requirements
- R1: While `trst_n` is low, the controller is in Test-Logic-Reset, the instruction latch holds IDCODE (3'b001), `tdo_oe_o` is 0, `float_o` is 0 and `sample_o` is 0.
- R2: Five consecutive rising `tck` edges with `tms` high bring the controller to Test-Logic-Reset from any state, and entering that state reloads the instruction latch with IDCODE.
- R3: State transitions follow the standard sixteen-state graph, sampled on the rising edge of `tck`.
- R4: `tdo_oe_o` is 1 exactly while the controller is in Shift-IR or Shift-DR. It and `tdo_o` are updated only on the falling edge of `tck`.
- R5: In every register, serial data enters at bit 0 from `tdi` and the most significant bit drives `tdo_o`, so a captured value leaves most significant bit first.
- R6: Capture-IR loads 3'b001 into the instruction shift stage. The latch takes the shifted value in Update-IR, and the first bit shifted in becomes bit 2.
- R7: The opcode selects the data register: 001 selects the 32-bit identification register; 010 and 100 select the boundary register; 000, 011, 101, 110 and 111 select the bypass register.
- R8: The identification word has bit 0 = 1, bits 7:1 = 7'b1011001, bits 11:8 = 4'b0001, bits 27:12 = 0, and bits 31:28 = the `REVISION` parameter.
- R9: `float_o` is 1 exactly while the latched opcode is 010.
- R10: `sample_o` is 1 during Capture-DR when opcode 010 or 100 is latched. The boundary register then captures `pins_i` at that rising edge.
- R11: The bypass register captures 0 in Capture-DR. In Shift-DR it delays `tdi` by exactly one `tck` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous power-up reset, active low |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in, sampled on rising `tck` |
| pins_i | input | BSR_LEN | Pin values presented for boundary capture |
| tdo_o | output | 1 | Serial data out, launched on falling `tck` |
| tdo_oe_o | output | 1 | Drive enable for the serial output pad |
| sample_o | output | 1 | Capture strobe for the functional pins |
| float_o | output | 1 | Request to float the data and match outputs |

## Verification
A wrong controller state is visible at the ports within half a `tck` cycle. `tdo_oe_o` rises or falls on the wrong falling edge, or `sample_o` appears outside Capture-DR. A wrong instruction latch shows at once on `float_o`. In the next data scan it also shows as a register of the wrong length, because the captured word appears at a different bit offset in the output stream. A corrupted shift stage shows as a wrong captured pattern or a wrong delay on the very next bits shifted out. The bench therefore follows every rising edge with a state model of its own and compares the enables and strobes on every cycle.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

  localparam int IR_W = 3;
  localparam int ID_W = 32;
  localparam int REV_W = 4;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_DR_SEL, ST_DR_CAP, ST_DR_SHIFT, ST_DR_EXIT1, ST_DR_PAUSE, ST_DR_EXIT2, ST_DR_UPD,
    ST_IR_SEL, ST_IR_CAP, ST_IR_SHIFT, ST_IR_EXIT1, ST_IR_PAUSE, ST_IR_EXIT2, ST_IR_UPD
  } tap_state_e;

  typedef enum logic [1:0] {SEL_BYPASS, SEL_IDENT, SEL_BOUND} dr_sel_e;

  localparam logic [IR_W-1:0] OPC_IDENT       = 3'b001;
  localparam logic [IR_W-1:0] OPC_PROBE_FLOAT = 3'b010;
  localparam logic [IR_W-1:0] OPC_PROBE       = 3'b100;
  localparam logic [IR_W-1:0] IR_CAPTURE_VAL  = 3'b001;

  function automatic tap_state_e tap_next(input tap_state_e st, input logic m);
    tap_state_e n;
    case (st)
      ST_RESET:    n = m ? ST_RESET    : ST_IDLE;
      ST_IDLE:     n = m ? ST_DR_SEL   : ST_IDLE;
      ST_DR_SEL:   n = m ? ST_IR_SEL   : ST_DR_CAP;
      ST_DR_CAP:   n = m ? ST_DR_EXIT1 : ST_DR_SHIFT;
      ST_DR_SHIFT: n = m ? ST_DR_EXIT1 : ST_DR_SHIFT;
      ST_DR_EXIT1: n = m ? ST_DR_UPD   : ST_DR_PAUSE;
      ST_DR_PAUSE: n = m ? ST_DR_EXIT2 : ST_DR_PAUSE;
      ST_DR_EXIT2: n = m ? ST_DR_UPD   : ST_DR_SHIFT;
      ST_DR_UPD:   n = m ? ST_DR_SEL   : ST_IDLE;
      ST_IR_SEL:   n = m ? ST_RESET    : ST_IR_CAP;
      ST_IR_CAP:   n = m ? ST_IR_EXIT1 : ST_IR_SHIFT;
      ST_IR_SHIFT: n = m ? ST_IR_EXIT1 : ST_IR_SHIFT;
      ST_IR_EXIT1: n = m ? ST_IR_UPD   : ST_IR_PAUSE;
      ST_IR_PAUSE: n = m ? ST_IR_EXIT2 : ST_IR_PAUSE;
      ST_IR_EXIT2: n = m ? ST_IR_UPD   : ST_IR_SHIFT;
      default:     n = m ? ST_DR_SEL   : ST_IDLE;
    endcase
    return n;
  endfunction

  function automatic dr_sel_e dr_select(input logic [IR_W-1:0] op);
    dr_sel_e s;
    case (op)
      OPC_IDENT:                  s = SEL_IDENT;
      OPC_PROBE_FLOAT, OPC_PROBE: s = SEL_BOUND;
      default:                    s = SEL_BYPASS;
    endcase
    return s;
  endfunction

  function automatic logic [ID_W-1:0] ident_word(input logic [REV_W-1:0] rev);
    logic [ID_W-1:0] w;
    w        = '0;
    w[0]     = 1'b1;
    w[7:1]   = 7'b1011001;
    w[11:8]  = 4'b0001;
    w[31:28] = rev;
    return w;
  endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import scan_tap_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_e st_o,
  output tap_state_e nx_o
);
  tap_state_e st_q;

  assign nx_o = tap_next(st_q, tms);
  assign st_o = st_q;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) st_q <= ST_RESET;
    else         st_q <= nx_o;
  end
endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import scan_tap_pkg::*;
(
  input  logic            tck,
  input  logic            trst_n,
  input  tap_state_e      st_i,
  input  tap_state_e      nx_i,
  input  logic            tdi_i,
  output logic [IR_W-1:0] lat_o,
  output logic [IR_W-1:0] sr_o
);
  logic [IR_W-1:0] sr_q, lat_q;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      sr_q <= '0;
    end else if (st_i == ST_IR_CAP) begin
      sr_q <= IR_CAPTURE_VAL;
    end else if (st_i == ST_IR_SHIFT) begin
      sr_q <= {sr_q[IR_W-2:0], tdi_i};
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      lat_q <= OPC_IDENT;
    end else if (nx_i == ST_RESET) begin
      lat_q <= OPC_IDENT;
    end else if (st_i == ST_IR_UPD) begin
      lat_q <= sr_q;
    end
  end

  assign lat_o = lat_q;
  assign sr_o  = sr_q;
endmodule

// File: rtl/tap_dr.sv
module tap_dr
  import scan_tap_pkg::*;
#(
  parameter int               BSR_LEN  = 54,
  parameter logic [REV_W-1:0] REVISION = 4'h3
) (
  input  logic               tck,
  input  logic               trst_n,
  input  tap_state_e         st_i,
  input  dr_sel_e            sel_i,
  input  logic               tdi_i,
  input  logic [BSR_LEN-1:0] pins_i,
  output logic               so_o,
  output logic               byp_o
);
  logic               byp_q;
  logic [ID_W-1:0]    id_q;
  logic [BSR_LEN-1:0] bsr_q;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      byp_q <= 1'b0;
      id_q  <= '0;
      bsr_q <= '0;
    end else if (st_i == ST_DR_CAP) begin
      case (sel_i)
        SEL_IDENT: id_q  <= ident_word(REVISION);
        SEL_BOUND: bsr_q <= pins_i;
        default:   byp_q <= 1'b0;
      endcase
    end else if (st_i == ST_DR_SHIFT) begin
      case (sel_i)
        SEL_IDENT: id_q  <= {id_q[ID_W-2:0], tdi_i};
        SEL_BOUND: bsr_q <= {bsr_q[BSR_LEN-2:0], tdi_i};
        default:   byp_q <= tdi_i;
      endcase
    end
  end

  always_comb begin
    case (sel_i)
      SEL_IDENT: so_o = id_q[ID_W-1];
      SEL_BOUND: so_o = bsr_q[BSR_LEN-1];
      default:   so_o = byp_q;
    endcase
  end

  assign byp_o = byp_q;
endmodule

// File: rtl/scan_tap.sv
module scan_tap
  import scan_tap_pkg::*;
#(
  parameter int               BSR_LEN  = 54,
  parameter logic [REV_W-1:0] REVISION = 4'h3
) (
  input  logic               tck,
  input  logic               trst_n,
  input  logic               tms,
  input  logic               tdi,
  input  logic [BSR_LEN-1:0] pins_i,
  output logic               tdo_o,
  output logic               tdo_oe_o,
  output logic               sample_o,
  output logic               float_o
);
  tap_state_e      st_q, st_nx;
  logic [IR_W-1:0] ir_lat, ir_sr;
  dr_sel_e         dr_sel;
  logic            dr_so, byp_q;
  logic            in_shift, serial_bit;

  tap_fsm u_fsm (
    .tck(tck), .trst_n(trst_n), .tms(tms), .st_o(st_q), .nx_o(st_nx)
  );

  tap_ir u_ir (
    .tck(tck), .trst_n(trst_n), .st_i(st_q), .nx_i(st_nx), .tdi_i(tdi),
    .lat_o(ir_lat), .sr_o(ir_sr)
  );

  assign dr_sel = dr_select(ir_lat);

  tap_dr #(.BSR_LEN(BSR_LEN), .REVISION(REVISION)) u_dr (
    .tck(tck), .trst_n(trst_n), .st_i(st_q), .sel_i(dr_sel), .tdi_i(tdi),
    .pins_i(pins_i), .so_o(dr_so), .byp_o(byp_q)
  );

  assign in_shift   = (st_q == ST_IR_SHIFT) || (st_q == ST_DR_SHIFT);
  assign serial_bit = (st_q == ST_IR_SHIFT) ? ir_sr[IR_W-1] : dr_so;

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo_o    <= 1'b0;
      tdo_oe_o <= 1'b0;
    end else begin
      tdo_o    <= in_shift ? serial_bit : 1'b0;
      tdo_oe_o <= in_shift;
    end
  end

  assign sample_o = (st_q == ST_DR_CAP) && (dr_sel == SEL_BOUND);
  assign float_o  = (ir_lat == OPC_PROBE_FLOAT);
endmodule

// File: rtl/scan_tap_chk.sv
module scan_tap_chk
  import scan_tap_pkg::*;
(
  input logic            tck,
  input logic            trst_n,
  input logic            tms,
  input logic            tdi,
  input logic            tdo_oe_o,
  input logic            sample_o,
  input logic            float_o,
  input tap_state_e      st_q,
  input logic [IR_W-1:0] ir_lat,
  input logic [IR_W-1:0] ir_sr,
  input dr_sel_e         dr_sel,
  input logic            byp_q
);
  logic [2:0] ones_cnt;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)       ones_cnt <= 3'd0;
    else if (!tms)     ones_cnt <= 3'd0;
    else if (ones_cnt != 3'd5) ones_cnt <= ones_cnt + 3'd1;
  end

  // R2
  five_ones_reset_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (ones_cnt == 3'd5) |-> (st_q == ST_RESET));

  // R2
  reset_opcode_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (st_q == ST_RESET) |-> (ir_lat == OPC_IDENT));

  // R4
  oe_on_shift_chk: assert property (@(negedge tck) disable iff (!trst_n)
    ((st_q == ST_IR_SHIFT) || (st_q == ST_DR_SHIFT)) |=> tdo_oe_o);

  // R4
  oe_off_chk: assert property (@(negedge tck) disable iff (!trst_n)
    !((st_q == ST_IR_SHIFT) || (st_q == ST_DR_SHIFT)) |=> !tdo_oe_o);

  // R6
  ir_capture_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (st_q == ST_IR_CAP) |=> (ir_sr == IR_CAPTURE_VAL));

  // R9
  float_rise_chk: assert property (@(posedge tck) disable iff (!trst_n)
    $rose(float_o) |-> $past(st_q == ST_IR_UPD));

  // R10
  sample_then_move_chk: assert property (@(posedge tck) disable iff (!trst_n)
    sample_o |=> ((st_q == ST_DR_SHIFT) || (st_q == ST_DR_EXIT1)));

  // R11
  bypass_delay_chk: assert property (@(posedge tck) disable iff (!trst_n)
    ((st_q == ST_DR_SHIFT) && (dr_sel == SEL_BYPASS)) |=> (byp_q == $past(tdi)));
endmodule

bind scan_tap scan_tap_chk chk_i (
  .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
  .tdo_oe_o(tdo_oe_o), .sample_o(sample_o), .float_o(float_o),
  .st_q(st_q), .ir_lat(ir_lat), .ir_sr(ir_sr), .dr_sel(dr_sel), .byp_q(byp_q)
);

// File: tb/scan_tap_tb_top.sv
`timescale 1ns/1ps
module scan_tap_tb_top;
  import scan_tap_pkg::*;

  localparam int BSR_LEN = 54;
  localparam logic [3:0] REV = 4'h3;

  logic tck = 1'b0;
  logic trst_n, tms, tdi;
  logic [BSR_LEN-1:0] pins;
  logic tdo_o, tdo_oe_o, sample_o, float_o;

  int n_vec = 0;
  int n_bad = 0;
  logic last_tdo, last_oe, last_smp;

  tap_state_e      st_m;
  logic [2:0]      lat_m, sr_m;

  always #2 tck = ~tck;

  scan_tap #(.BSR_LEN(BSR_LEN), .REVISION(REV)) dut_i (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .pins_i(pins),
    .tdo_o(tdo_o), .tdo_oe_o(tdo_oe_o), .sample_o(sample_o), .float_o(float_o)
  );

  function automatic tap_state_e m_next(input tap_state_e s, input logic m);
    tap_state_e hi, lo;
    hi = ST_DR_SEL; lo = ST_IDLE;
    case (s)
      ST_RESET:    begin hi = ST_RESET;    lo = ST_IDLE;     end
      ST_DR_SEL:   begin hi = ST_IR_SEL;   lo = ST_DR_CAP;   end
      ST_IR_SEL:   begin hi = ST_RESET;    lo = ST_IR_CAP;   end
      ST_DR_CAP, ST_DR_SHIFT: begin hi = ST_DR_EXIT1; lo = ST_DR_SHIFT; end
      ST_IR_CAP, ST_IR_SHIFT: begin hi = ST_IR_EXIT1; lo = ST_IR_SHIFT; end
      ST_DR_EXIT1: begin hi = ST_DR_UPD;   lo = ST_DR_PAUSE; end
      ST_IR_EXIT1: begin hi = ST_IR_UPD;   lo = ST_IR_PAUSE; end
      ST_DR_PAUSE: begin hi = ST_DR_EXIT2; lo = ST_DR_PAUSE; end
      ST_IR_PAUSE: begin hi = ST_IR_EXIT2; lo = ST_IR_PAUSE; end
      ST_DR_EXIT2: begin hi = ST_DR_UPD;   lo = ST_DR_SHIFT; end
      ST_IR_EXIT2: begin hi = ST_IR_UPD;   lo = ST_IR_SHIFT; end
      default: ;
    endcase
    return m ? hi : lo;
  endfunction

  function automatic int reg_len(input logic [2:0] op);
    if (op == 3'b001) return 32;
    if (op == 3'b010 || op == 3'b100) return BSR_LEN;
    return 1;
  endfunction

  function automatic logic [31:0] exp_id();
    return {REV, 16'h0000, 4'b0001, 7'b1011001, 1'b1};
  endfunction

  function automatic logic [63:0] exp_scan(input logic [63:0] cap, input int len,
                                           input logic [63:0] din);
    return (cap << (64 - len)) | (din >> len);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input logic t_ms, input logic t_di);
    tap_state_e nx;
    logic eoe, esmp;
    tms = t_ms; tdi = t_di;
    @(negedge tck); #1;
    last_tdo = tdo_o; last_oe = tdo_oe_o; last_smp = sample_o;
    eoe  = (st_m == ST_IR_SHIFT) || (st_m == ST_DR_SHIFT);
    esmp = (st_m == ST_DR_CAP) && (lat_m == 3'b010 || lat_m == 3'b100);
    chk(last_oe == eoe, "R3,R4 tdo_oe", 64'(last_oe), 64'(eoe));
    chk(float_o == (lat_m == 3'b010), "R9 float", 64'(float_o), 64'(lat_m == 3'b010));
    chk(last_smp == esmp, "R10 sample strobe", 64'(last_smp), 64'(esmp));
    if (st_m == ST_IR_SHIFT)
      chk(last_tdo == sr_m[2], "R5 ir serial out", 64'(last_tdo), 64'(sr_m[2]));
    nx = m_next(st_m, t_ms);
    if (nx == ST_RESET) lat_m = 3'b001;
    else if (st_m == ST_IR_UPD) lat_m = sr_m;
    if (st_m == ST_IR_CAP) sr_m = 3'b001;
    else if (st_m == ST_IR_SHIFT) sr_m = {sr_m[1:0], t_di};
    st_m = nx;
    @(posedge tck); #1;
  endtask

  // from Run-Test/Idle back to Run-Test/Idle
  task automatic load_ir(input logic [2:0] op);
    logic [2:0] seen;
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 2; i >= 0; i--) begin
      tick(i == 0, op[i]);
      seen[i] = last_tdo;
    end
    chk(seen == 3'b001, "R6 ir capture pattern", 64'(seen), 64'h1);
    tick(1, 0); tick(0, 0);
  endtask

  task automatic scan_dr(input logic [63:0] din, output logic [63:0] dout,
                         output logic smp);
    dout = '0;
    tick(1, 0); tick(0, 0); tick(0, 0);
    smp = last_smp;
    for (int i = 63; i >= 0; i--) begin
      tick(i == 0, din[i]);
      dout = {dout[62:0], last_tdo};
    end
    tick(1, 0); tick(0, 0);
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", n_vec, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] din, dout;
    logic smp;
    void'($urandom(32'h5EED_7A9));
    trst_n = 1'b0; tms = 1'b1; tdi = 1'b0;
    pins = {$urandom, $urandom};
    st_m = ST_RESET; lat_m = 3'b001; sr_m = 3'b000;
    #5;
    // R1 reset state
    chk(tdo_oe_o == 1'b0, "R1 tdo_oe in reset", 64'(tdo_oe_o), 64'h0);
    chk(float_o == 1'b0, "R1 float in reset", 64'(float_o), 64'h0);
    chk(sample_o == 1'b0, "R1 sample in reset", 64'(sample_o), 64'h0);
    #4 trst_n = 1'b1;
    @(posedge tck); #1;
    tick(0, 0);
    // R1 R8 default instruction selects identification word
    din = {$urandom, $urandom};
    scan_dr(din, dout, smp);
    chk(dout == exp_scan(64'(exp_id()), 32, din), "R8 R5 ident readout", dout,
        exp_scan(64'(exp_id()), 32, din));
    // R11 bypass one-cycle delay
    load_ir(3'b000);
    din = 64'hA5C3_0F96_1234_8001;
    scan_dr(din, dout, smp);
    chk(dout == (din >> 1), "R11 bypass delay", dout, din >> 1);
    // R7 every opcode
    for (int op = 0; op < 8; op++) begin
      logic [63:0] cap;
      int len;
      load_ir(3'(op));
      chk(float_o == (op == 2), "R9 float per opcode", 64'(float_o), 64'(op == 2));
      len = reg_len(3'(op));
      pins = {$urandom, $urandom};
      cap = (len == 32) ? 64'(exp_id()) : (len == BSR_LEN) ? 64'(pins) : 64'h0;
      din = {$urandom, $urandom};
      scan_dr(din, dout, smp);
      chk(dout == exp_scan(cap, len, din), "R7 R10 register per opcode", dout,
          exp_scan(cap, len, din));
      chk(smp == (len == BSR_LEN), "R10 capture strobe", 64'(smp), 64'(len == BSR_LEN));
    end
    // R3 random walk through the state graph
    for (int k = 0; k < 800; k++) begin
      logic m;
      m = ($urandom % 3) == 0;
      tick(m, 1'($urandom));
    end
    // R2 five ones from Shift-DR with the float opcode latched
    tick(1, 0); tick(1, 0); tick(1, 0); tick(1, 0); tick(1, 0); tick(0, 0);
    load_ir(3'b010);
    chk(float_o == 1'b1, "R9 float set", 64'(float_o), 64'h1);
    tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < 5; i++) tick(1, 1);
    chk(float_o == 1'b0, "R2 five ones reload", 64'(float_o), 64'h0);
    tick(0, 0);
    din = {$urandom, $urandom};
    scan_dr(din, dout, smp);
    chk(dout == exp_scan(64'(exp_id()), 32, din), "R2 ident after reset", dout,
        exp_scan(64'(exp_id()), 32, din));
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule